// File: doc/BRIEF.md
# Dual LED Blink Controller

This block drives two indicator lamps, one red and one blue, from a small set of static control fields. Each lamp has its own 2-bit brightness/blink code that selects what fraction of a repeating blink period the lamp is lit. Each lamp also has a force-off control and a pulse-saving option. When that option is on and the full-on code is chosen, the lamp is driven by a fast square wave instead of a steady level. The square wave is too fast to see and halves the drive energy.

A prescaler divides the clock into ticks, and a 3-bit phase counter advances on every step. Each step is one tick, or every second tick when the shared half-rate control is set. The blue lamp can be switched to show a signal-detected flag instead of its own pattern. That flag is captured only on step strobes, so the half-rate control also halves how often detection is sampled.

Top module: `led_blink_ctrl`

## Requirements
- R1: With a lamp not forced off and pulsing off, code 2'b00 lights it in all 8 phases, 2'b01 in phases 0..3, 2'b10 in phases 0..1 and 2'b11 only in phase 0 (phase = the 3-bit step count modulo 8).
- R2: When a lamp's force-off input is 1 that lamp output is 0, whatever its code, pulse option, phase or detect flag.
- R3: With code 2'b00 and the pulse option set, the lamp equals the MSB of a MOD_W-bit counter. This counter advances every clock and is cleared by reset, so the lamp is lit 50% of the time.
- R4: The pulse option has no effect when a lamp's code is not 2'b00.
- R5: With half-rate set, the phase advances once every 2*PRESCALE clocks.
- R6: With follow set, the blue output equals the captured detect flag (when not forced off), and the red output is unaffected.
- R7: The detect flag is captured only on edges where the phase advances, so half-rate also halves the detect sampling rate.
- R8: During reset the phase, the pulse counter and the captured detect flag are all 0.
- R9: With half-rate clear, the phase advances once every PRESCALE clocks, the first advance taking place on the PRESCALE-th edge after reset release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| red_duty | input | 2 | Red lit-fraction code |
| red_off | input | 1 | Force red off |
| red_mod | input | 1 | Red pulse option at full duty |
| blue_duty | input | 2 | Blue lit-fraction code |
| blue_off | input | 1 | Force blue off |
| blue_mod | input | 1 | Blue pulse option at full duty |
| blue_follow | input | 1 | Blue shows captured detect flag |
| half_rate | input | 1 | Halve step and detect sampling rate |
| detect | input | 1 | Signal-detected flag |
| led_red | output | 1 | Red lamp enable |
| led_blue | output | 1 | Blue lamp enable |

## Verification
The bench builds the block with PRESCALE=3 and MOD_W=2, so a full 8-phase period is only 24 or 48 clocks and the pulse wave has a 4-clock period. Those values let every clock of more than two whole periods be checked against every combination of code, pulse option and force-off, for both lamps, in all four half-rate/follow settings. A detect input that toggles every 5 clocks is deliberately out of step with the capture strobes, which shows whether the flag is captured only on step edges.

// File: rtl/led_blink_ctrl.sv
module led_blink_ctrl #(
  parameter int PRESCALE = 1000000,
  parameter int PHASE_W  = 3,
  parameter int MOD_W    = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] red_duty,
  input  logic       red_off,
  input  logic       red_mod,
  input  logic [1:0] blue_duty,
  input  logic       blue_off,
  input  logic       blue_mod,
  input  logic       blue_follow,
  input  logic       half_rate,
  input  logic       detect,
  output logic       led_red,
  output logic       led_blue
);
  localparam int PS_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam logic [PS_W-1:0] PS_LAST = PS_W'(PRESCALE - 1);
  localparam logic [PS_W-1:0] PS_ONE = PS_W'(1);
  localparam logic [PHASE_W:0] FULL = (PHASE_W+1)'(1 << PHASE_W);

  logic [PS_W-1:0]    ps_cnt;
  logic               half_ph;
  logic [PHASE_W-1:0] phase;
  logic [MOD_W-1:0]   mod_cnt;
  logic               det_q;
  logic               tick, step, mod_pulse;
  logic [PHASE_W:0]   red_thr, blue_thr;
  logic               red_pat, blue_pat;

  assign tick = (ps_cnt == PS_LAST);
  assign step = tick && (!half_rate || half_ph);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ps_cnt  <= '0;
      half_ph <= 1'b0;
      phase   <= '0;
      mod_cnt <= '0;
      det_q   <= 1'b0;
    end else begin
      ps_cnt  <= tick ? '0 : ps_cnt + PS_ONE;
      mod_cnt <= mod_cnt + MOD_W'(1);
      if (tick) half_ph <= ~half_ph;
      if (step) begin
        phase <= phase + PHASE_W'(1);
        det_q <= detect;
      end
    end
  end

  assign mod_pulse = mod_cnt[MOD_W-1];
  assign red_thr   = FULL >> red_duty;
  assign blue_thr  = FULL >> blue_duty;

  assign red_pat  = ({1'b0, phase} < red_thr) &&
                    !(red_mod && red_duty == 2'b00 && !mod_pulse);
  assign blue_pat = ({1'b0, phase} < blue_thr) &&
                    !(blue_mod && blue_duty == 2'b00 && !mod_pulse);

  assign led_red  = !red_off && red_pat;
  assign led_blue = !blue_off && (blue_follow ? det_q : blue_pat);
endmodule

module led_blink_ctrl_chk #(
  parameter int PHASE_W = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic [1:0]         red_duty,
  input logic               red_off,
  input logic               red_mod,
  input logic               blue_off,
  input logic               blue_follow,
  input logic               led_red,
  input logic               led_blue,
  input logic [PHASE_W-1:0] phase,
  input logic               step,
  input logic               det_q
);
  AST_RED_FORCED_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    red_off |-> !led_red); // R2
  AST_BLUE_FORCED_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    blue_off |-> !led_blue); // R2
  AST_FULL_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    (red_duty == 2'b00 && !red_mod && !red_off) |-> led_red); // R1
  AST_EIGHTH_ONLY_PHASE0: assert property (@(posedge clk) disable iff (!rst_n)
    (red_duty == 2'b11 && phase != '0) |-> !led_red); // R1
  AST_PHASE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(phase)); // R9
  AST_DET_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(det_q)); // R7
  AST_BLUE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (blue_follow && !blue_off) |-> (led_blue == det_q)); // R6
endmodule

bind led_blink_ctrl led_blink_ctrl_chk #(.PHASE_W(PHASE_W)) u_chk (.*);

// File: tb/led_blink_ctrl_test.sv
`timescale 1ns/1ps
module led_blink_ctrl_test;
  localparam int P    = 3;
  localparam int MW   = 2;
  localparam int NCYC = P * 2 * 8 * 2 + 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] red_duty = '0, blue_duty = '0;
  logic red_off = 0, red_mod = 0, blue_off = 0, blue_mod = 0;
  logic blue_follow = 0, half_rate = 0, detect = 0;
  logic led_red, led_blue;

  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  led_blink_ctrl #(.PRESCALE(P), .PHASE_W(3), .MOD_W(MW)) uut (
    .clk(clk), .rst_n(rst_n),
    .red_duty(red_duty), .red_off(red_off), .red_mod(red_mod),
    .blue_duty(blue_duty), .blue_off(blue_off), .blue_mod(blue_mod),
    .blue_follow(blue_follow), .half_rate(half_rate), .detect(detect),
    .led_red(led_red), .led_blue(led_blue));

  function automatic bit lamp(input int duty, input bit md, input bit off,
                              input int ph, input bit mb);
    if (off) return 0;
    if (ph >= (8 >> duty)) return 0;
    if (md && duty == 0 && !mb) return 0;
    return 1;
  endfunction

  function automatic string req_of(input int duty, input bit md, input bit off,
                                   input string rate);
    if (off) return "R2";
    if (md && duty == 0) return "R3";
    if (md) return "R4";
    return {"R1/", rate};
  endfunction

  function automatic int steps_at(input int k, input bit hr);
    return hr ? (k / P) / 2 : k / P;
  endfunction

  task automatic check(input bit act, input bit exp, input string what, input string rq);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0b expected=%0b", rq, what, act, exp);
    end
  endtask

  task automatic check_all(input int ph, input bit mb, input bit det,
                           input bit fol, input string rate);
    for (int i = 0; i < 16; i++) begin
      red_duty = i[1:0]; red_mod = i[2]; red_off = i[3];
      blue_duty = 2'(3 - i[1:0]); blue_mod = i[3]; blue_off = i[2];
      #0.1;
      check(led_red, lamp(i % 4, i[2], i[3], ph, mb),
            $sformatf("red i=%0d ph=%0d", i, ph), req_of(i % 4, i[2], i[3], rate));
      if (fol)
        check(led_blue, !i[2] && det, $sformatf("blue follow i=%0d", i),
              i[2] ? "R2" : "R6/R7");
      else
        check(led_blue, lamp(3 - i % 4, i[3], i[2], ph, mb),
              $sformatf("blue i=%0d ph=%0d", i, ph),
              req_of(3 - i % 4, i[3], i[2], rate));
    end
  endtask

  task automatic run_cfg(input bit hr, input bit fol);
    bit det_exp;
    string rate;
    rate = hr ? "R5" : "R9";
    half_rate = hr; blue_follow = fol; detect = 1'b0;
    rst_n = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check_all(0, 0, 0, fol, "R8");
    det_exp = 0;
    rst_n = 1'b1;
    detect = 1'b1;
    for (int k = 1; k <= NCYC; k++) begin
      @(posedge clk);
      if (steps_at(k, hr) != steps_at(k - 1, hr)) det_exp = detect;
      @(negedge clk);
      check_all(steps_at(k, hr) % 8, ((k >> (MW - 1)) & 1) != 0, det_exp, fol, rate);
      detect = ((k / 5) % 2) == 0;
    end
  endtask

  initial begin
    run_cfg(0, 0);
    run_cfg(1, 0);
    run_cfg(0, 1);
    run_cfg(1, 1);
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #(8.0 * 200000);
    if (!done) begin
      done = 1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule